// File: doc/BRIEF.md
# Selection Waiting List Manager

This block tracks the command-block indices that are waiting to be selected on the bus. It keeps them as a singly linked list. A head register names the first entry, and a small next-pointer RAM with one word per index holds each entry's link. The all-ones index code is reserved as the null link. It marks both an empty list and the end of the list. Every other code is a valid index.

New entries go in at the head. This covers commands fetched from the host queue, and also follow-up commands generated inside the controller, such as a sense request or a second untagged command queued behind a pending one. The head is always presented to the selection engine. When the engine reports a won selection, the head is unlinked by loading its stored link into the head register. The unlinked entry's link word is left as it was.

When a reselection takes the bus instead, the engine simply does not acknowledge, and the same head is offered again for the retry. A non-empty list tells the controller to serve it before fetching any new host work.

Top module: `selwait_list`

## Requirements
- R1: During and after a synchronous reset, the outputs are as follows: `head_idx` is the null code (all ones), `list_empty` is 1, `head_valid` is 0 and `push_err` is 0.
- R2: A push of a non-null index makes that index `head_idx` on the clock edge that samples it.
- R3: A pop acknowledge on a non-empty list, with no push in the same cycle, replaces `head_idx` with the index that was at the head before the removed entry was pushed. The order is last in, first out.
- R4: A pop acknowledge while the list is empty is ignored: the list stays empty and `head_idx` stays null.
- R5: In a cycle with neither push nor pop acknowledge, `head_idx` holds. A head that lost arbitration is therefore offered again unchanged.
- R6: When push and pop acknowledge fall in the same cycle, the pop is applied first. The pushed index becomes the head, and its link points to the head that the pop left behind, so no entry is lost.
- R7: A push of the null code changes nothing in the list. It raises `push_err` for exactly the one cycle after it is sampled. The pop in that same cycle still takes effect.
- R8: `list_empty` is 1 exactly when `head_idx` is the null code, and `head_valid` is always the inverse of `list_empty`.
- R9: The list can hold every valid index at once (2^IDX_W - 1 entries). Popping a full list returns the indices in the reverse of their push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push request for `push_idx` this cycle |
| push_idx | input | IDX_W | Index to link in at the head |
| pop_ack | input | 1 | Selection of the head succeeded; unlink it |
| head_valid | output | 1 | The list holds at least one entry |
| head_idx | output | IDX_W | Index at the head (null code when empty) |
| list_empty | output | 1 | The list is empty |
| push_err | output | 1 | One-cycle pulse after a push of the null code |

## Verification
A push and a pop acknowledge can land on the same clock edge. In that case the link written for the new entry must take the head left behind by the pop, not the old head. The read of the link RAM must also see a write made to the very index it is reading.

The bench provokes this in three ways. It runs directed back-to-back swaps, runs swaps on a one-entry list and on an empty list, and mixes swaps into a long seeded random sequence. Every result is judged against a last-in, first-out queue model kept in the bench. The model applies the pop before the push and compares the head and flags after every cycle.

// File: rtl/selwait_pkg.sv
package selwait_pkg;
  // Decoded list operation for one cycle.
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } list_op_e;
endpackage

// File: rtl/selwait_link_ram.sv
// Next-pointer storage: one write port, one registered read port.
// A write to the address being read forwards the new data (write-first).
module selwait_link_ram #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [IDX_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [IDX_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr == rd_addr)) rd_data <= wr_data;
    else                               rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/selwait_head_ctrl.sv
// Head register, operation decode and next-state computation.
module selwait_head_ctrl
  import selwait_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop_ack,
  input  logic [IDX_W-1:0] link_q,
  output logic             ram_we,
  output logic [IDX_W-1:0] ram_waddr,
  output logic [IDX_W-1:0] ram_wdata,
  output logic [IDX_W-1:0] ram_raddr,
  output logic [IDX_W-1:0] head_q,
  output logic             empty_q,
  output logic             err_q
);
  localparam logic [IDX_W-1:0] NULL_IDX = {IDX_W{1'b1}};

  list_op_e         op;
  logic             push_ok;
  logic             pop_ok;
  logic [IDX_W-1:0] after_pop;
  logic [IDX_W-1:0] head_nxt;

  assign push_ok = push_valid && (push_idx != NULL_IDX);
  assign pop_ok  = pop_ack && !empty_q;

  always_comb begin
    unique case ({pop_ok, push_ok})
      2'b01:   op = OP_PUSH;
      2'b10:   op = OP_POP;
      2'b11:   op = OP_SWAP;
      default: op = OP_IDLE;
    endcase
  end

  always_comb begin
    after_pop = head_q;
    head_nxt  = head_q;
    unique case (op)
      OP_PUSH: head_nxt = push_idx;
      OP_POP: begin
        after_pop = link_q;
        head_nxt  = link_q;
      end
      OP_SWAP: begin
        after_pop = link_q;
        head_nxt  = push_idx;
      end
      default: ;
    endcase
  end

  // The new entry links to the head left after any same-cycle pop.
  assign ram_we    = push_ok && !rst;
  assign ram_waddr = push_idx;
  assign ram_wdata = after_pop;
  // Keep the RAM output aligned with the link of the next head.
  assign ram_raddr = head_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= NULL_IDX;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      head_q  <= head_nxt;
      empty_q <= (head_nxt == NULL_IDX);
      err_q   <= push_valid && (push_idx == NULL_IDX);
    end
  end

  a_r2_push_sets_head: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> head_q == $past(push_idx));

  a_r3_pop_takes_link: assert property (@(posedge clk) disable iff (rst)
    (pop_ok && !push_ok) |=> head_q == $past(link_q));

  a_r4_pop_empty_ignored: assert property (@(posedge clk) disable iff (rst)
    (pop_ack && empty_q && !push_ok) |=> empty_q);

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!push_valid && !pop_ack) |=> $stable(head_q));

  a_r7_null_push_pulse: assert property (@(posedge clk) disable iff (rst)
    (push_valid && push_idx == NULL_IDX && !pop_ack) |=> (err_q && $stable(head_q)));

  a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(push_valid && push_idx == NULL_IDX)) |=> !err_q);
endmodule

// File: rtl/selwait_list.sv
// Waiting list of command-block indices awaiting bus selection.
module selwait_list #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop_ack,
  output logic             head_valid,
  output logic [IDX_W-1:0] head_idx,
  output logic             list_empty,
  output logic             push_err
);
  localparam logic [IDX_W-1:0] NULL_IDX = {IDX_W{1'b1}};

  logic             ram_we;
  logic [IDX_W-1:0] ram_waddr;
  logic [IDX_W-1:0] ram_wdata;
  logic [IDX_W-1:0] ram_raddr;
  logic [IDX_W-1:0] link_q;
  logic             empty_q;

  selwait_head_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .push_idx   (push_idx),
    .pop_ack    (pop_ack),
    .link_q     (link_q),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .ram_wdata  (ram_wdata),
    .ram_raddr  (ram_raddr),
    .head_q     (head_idx),
    .empty_q    (empty_q),
    .err_q      (push_err)
  );

  selwait_link_ram #(.IDX_W(IDX_W)) u_links (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_addr (ram_waddr),
    .wr_data (ram_wdata),
    .rd_addr (ram_raddr),
    .rd_data (link_q)
  );

  assign list_empty = empty_q;
  assign head_valid = !empty_q;

  a_r8_empty_matches_head: assert property (@(posedge clk) disable iff (rst)
    list_empty == (head_idx == NULL_IDX));

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (list_empty && head_idx == NULL_IDX && !push_err));
endmodule

// File: tb/selwait_list_tb_top.sv
module selwait_list_tb_top;
  localparam int W = 4;
  localparam int NUL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         push_valid = 1'b0;
  logic [W-1:0] push_idx = '0;
  logic         pop_ack = 1'b0;
  logic         head_valid;
  logic [W-1:0] head_idx;
  logic         list_empty;
  logic         push_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int   model[$];
  bit [NUL:0] inlist = '0;

  always #5 clk = ~clk;

  selwait_list #(.IDX_W(W)) dut_i (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_idx(push_idx),
    .pop_ack(pop_ack), .head_valid(head_valid), .head_idx(head_idx),
    .list_empty(list_empty), .push_err(push_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, apply model, sample after the edge.
  task automatic step(input bit pv, input int pi, input bit pop, input string tag);
    int exp_head;
    bit exp_err;
    @(negedge clk);
    push_valid = pv;
    push_idx = W'(pi);
    pop_ack = pop;
    exp_err = pv && (pi == NUL);
    if (pop && model.size() > 0) begin
      inlist[model[0]] = 1'b0;
      void'(model.pop_front());
    end
    if (pv && pi != NUL) begin
      model.push_front(pi);
      inlist[pi] = 1'b1;
    end
    exp_head = (model.size() > 0) ? model[0] : NUL;
    @(posedge clk);
    #1;
    chk(int'(head_idx) == exp_head, tag, int'(head_idx), exp_head);
    chk(list_empty == (exp_head == NUL), "R8 empty", int'(list_empty), int'(exp_head == NUL));
    chk(head_valid == (exp_head != NUL), "R8 valid", int'(head_valid), int'(exp_head != NUL));
    chk(push_err == exp_err, "R7 err", int'(push_err), int'(exp_err));
    push_valid = 1'b0;
    pop_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk(int'(head_idx) == NUL, "R1 head", int'(head_idx), NUL);
    chk(list_empty == 1'b1, "R1 empty", int'(list_empty), 1);
    chk(head_valid == 1'b0, "R1 valid", int'(head_valid), 0);
    chk(push_err == 1'b0, "R1 err", int'(push_err), 0);
    @(negedge clk);
    rst = 1'b0;
    step(0, 0, 0, "R1 after reset");
    // R4 pop on empty
    step(0, 0, 1, "R4 pop empty");
    step(0, 0, 1, "R4 pop empty");
    // R9 fill every valid index, then drain in reverse
    for (int i = 0; i < NUL; i++) step(1, i, 0, "R2 fill");
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R5 hold full");
    for (int i = 0; i < NUL; i++) step(0, 0, 1, "R9 drain");
    step(0, 0, 1, "R4 pop after drain");
    // R6 swap on empty, one-entry, and deeper lists
    step(1, 5, 1, "R6 swap empty");
    step(1, 7, 1, "R6 swap one");
    step(1, 2, 0, "R2 push");
    step(1, 9, 1, "R6 swap two");
    step(1, 3, 1, "R6 swap two");
    step(0, 0, 1, "R3 pop");
    step(0, 0, 1, "R3 pop");
    // R7 null pushes, alone and with a pop
    step(1, NUL, 0, "R7 null empty");
    step(1, 4, 0, "R2 push");
    step(1, 6, 0, "R2 push");
    step(1, NUL, 0, "R7 null");
    step(0, 0, 0, "R7 pulse ends");
    step(1, NUL, 1, "R7 null with pop");
    step(1, NUL, 1, "R7 null with pop");
    step(0, 0, 0, "R5 idle");
    // Random mix against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      int cand;
      bit pv;
      bit pop;
      r = int'($urandom_range(0, 99));
      pop = (r % 3) == 0;
      pv = 1'b0;
      cand = int'($urandom_range(0, NUL));
      if (cand == NUL) pv = (r < 10);
      else if (!inlist[cand] || (pop && model.size() > 0 && model[0] == cand)) pv = (r < 60);
      if (pv && pop) step(1, cand, 1, "R6 random swap");
      else if (pv) step(1, cand, 0, "R2 random push");
      else if (pop) step(0, 0, 1, "R3 random pop");
      else step(0, 0, 0, "R5 random idle");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end
endmodule